// File: doc/BRIEF.md
# Shift, Rotate, Compare and Logic Execution Unit

This block is the integer execute stage for register-to-register operations that need no multiplier or divider. Each cycle it can accept one operation: two 32-bit operands, a 5-bit immediate shift amount and a 5-bit operation code. One clock later it presents the 32-bit value meant for the destination register. The arithmetic, the logic, the barrel shifter and the comparator are all combinational. A single output register, qualified by a valid flag, separates this block from the writeback stage that follows it.

The shifter handles logical and arithmetic shifts and rotates in both directions. The amount comes either from the low bits of operand B or from the immediate field, depending on the operation. Comparisons place a 0 or a 1 in the destination word, which suits set-on-condition instructions. Register-file access, branches, multiplication and division belong to other blocks.

Top module: `sr_exu_top`

## Requirements
- R1: ADD (code 0) returns A+B and SUB (code 1) returns A-B, both wrapping modulo 2^32.
- R2: AND (2), OR (3) and XOR (4) are bitwise. NOR (5) returns the bitwise complement of A|B.
- R3: The register-amount shift and rotate codes SLL (6), SRL (7), SRA (8), ROL (9) and ROR (10) take their amount from B[4:0]. Bits B[31:5] have no effect on the result.
- R4: The immediate codes SLLI (11), SRLI (12), SRAI (13) and ROLI (14) take their amount from imm_amt. The value of B has no effect on them.
- R5: SLL and SLLI fill the vacated low bits with zeros. SRL and SRLI fill the vacated high bits with zeros. SRA and SRAI fill the vacated high bits with copies of A[31].
- R6: Rotate left by n returns (A<<n)|(A>>(32-n)). Rotate right by n returns (A>>n)|(A<<(32-n)). Any shift or rotate by an amount of 0 returns A unchanged.
- R7: CMPLT (17) and CMPGE (18) compare A with B as signed two's-complement values.
- R8: CMPLTU (19) and CMPGEU (20) compare A with B as unsigned values.
- R9: CMPEQ (15) is true when A equals B. CMPNE (16) is true when A differs from B.
- R10: Every compare code returns exactly 1 when its condition holds and 0 when it does not.
- R11: Op codes 21 to 31 are unused and return a result of zero.
- R12: When in_valid is sampled high, out_valid and result carry that operation's value after one clock edge. When in_valid is low, out_valid drops and result holds its previous value. A synchronous active-low reset clears both out_valid and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or the shift amount for register forms |
| imm_amt | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Result register holds a fresh value |
| result | output | 32 | Value for the destination register |

## Verification
The bench concentrates on shift amounts of 0, 1 and 31, and on register-form amounts whose upper bits in B are set.

A design that used all of B would return zero or a wrongly wrapped value for these amounts. A rotate that is mishandled at 0 would OR in a full copy of A shifted by 32. Signed-compare operand pairs straddle the sign boundary, such as 0x7FFFFFFF against 0x80000000, so a signed/unsigned mix-up flips the answer. Operands with a negative A expose an arithmetic right shift that fills with zeros. Unused codes are driven with nonzero operands, so leakage from a neighbouring unit shows up as a nonzero result.

// File: rtl/sr_exu_pkg.sv
// Package: shared operation codes and shifter variants for the execute unit.
// Assumes a 5-bit operation code. The numeric values are part of the interface.
package sr_exu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_AND    = 5'd2,
        OP_OR     = 5'd3,
        OP_XOR    = 5'd4,
        OP_NOR    = 5'd5,
        OP_SLL    = 5'd6,
        OP_SRL    = 5'd7,
        OP_SRA    = 5'd8,
        OP_ROL    = 5'd9,
        OP_ROR    = 5'd10,
        OP_SLLI   = 5'd11,
        OP_SRLI   = 5'd12,
        OP_SRAI   = 5'd13,
        OP_ROLI   = 5'd14,
        OP_CMPEQ  = 5'd15,
        OP_CMPNE  = 5'd16,
        OP_CMPLT  = 5'd17,
        OP_CMPGE  = 5'd18,
        OP_CMPLTU = 5'd19,
        OP_CMPGEU = 5'd20
    } exu_op_e;

    typedef enum logic [2:0] {
        SK_SHL,
        SK_SHR,
        SK_SAR,
        SK_ROL,
        SK_ROR
    } shift_kind_e;

    // True for any shift or rotate code.
    function automatic logic op_is_shift(logic [OP_W-1:0] op);
        return (op >= OP_SLL) && (op <= OP_ROLI);
    endfunction

    // True for the immediate-amount forms.
    function automatic logic op_is_imm(logic [OP_W-1:0] op);
        return (op >= OP_SLLI) && (op <= OP_ROLI);
    endfunction

    // True for any compare code.
    function automatic logic op_is_cmp(logic [OP_W-1:0] op);
        return (op >= OP_CMPEQ) && (op <= OP_CMPGEU);
    endfunction

    // True for either rotate direction.
    function automatic logic op_is_rot(logic [OP_W-1:0] op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_ROLI);
    endfunction

endpackage

// File: rtl/sr_exu_arith.sv
// Module: add, subtract and the four bitwise operations.
// Assumes the caller selects this output only for codes ADD..NOR.
// Returns zero for any other code.
module sr_exu_arith
    import sr_exu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);

    // Pick the arithmetic or bitwise function for the code.
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sr_exu_shift.sv
// Module: logarithmic barrel shifter built from right-shifting stages.
// Left shifts and left rotates reverse the bit order before and after the
// stages, so one right-shifting core serves all five variants.
// Assumes W is a power of two and AW = log2(W).
module sr_exu_shift
    import sr_exu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  dout
);

    localparam int STAGES = AW;

    logic          flip;
    logic          rot;
    logic          fill_bit;
    logic [W-1:0]  core_in;
    logic [W-1:0]  stg [STAGES+1];

    // Decode the variant into a reversal, a wrap and a fill bit.
    always_comb begin
        flip     = (kind == SK_SHL) || (kind == SK_ROL);
        rot      = (kind == SK_ROL) || (kind == SK_ROR);
        fill_bit = (kind == SK_SAR) ? din[W-1] : 1'b0;
    end

    // Reverse the operand for the left-going variants.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            core_in[i] = flip ? din[W-1-i] : din[i];
        end
    end

    assign stg[0] = core_in;

    // One stage per amount bit, each moving the word right by 2**k.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int SH = 1 << k;
        logic [SH-1:0] fill;
        always_comb begin
            fill = rot ? stg[k][SH-1:0] : {SH{fill_bit}};
        end
        assign stg[k+1] = amt[k] ? {fill, stg[k][W-1:SH]} : stg[k];
    end

    // Undo the reversal on the way out.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            dout[i] = flip ? stg[STAGES][W-1-i] : stg[STAGES][i];
        end
    end

endmodule

// File: rtl/sr_exu_cmp.sv
// Module: comparator producing a 0/1 word for the six compare codes.
// Assumes the caller selects this output only for compare codes.
// Returns zero for any other code.
module sr_exu_cmp
    import sr_exu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);

    logic eq;
    logic lt_s;
    logic lt_u;
    logic hit;

    // Form the three base relations once.
    always_comb begin
        eq   = (a == b);
        lt_u = (a < b);
        lt_s = ($signed(a) < $signed(b));
    end

    // Map the code onto one relation or its inverse.
    always_comb begin
        unique case (op)
            OP_CMPEQ:  hit = eq;
            OP_CMPNE:  hit = !eq;
            OP_CMPLT:  hit = lt_s;
            OP_CMPGE:  hit = !lt_s;
            OP_CMPLTU: hit = lt_u;
            OP_CMPGEU: hit = !lt_u;
            default:   hit = 1'b0;
        endcase
        y = {{(W-1){1'b0}}, hit};
    end

endmodule

// File: rtl/sr_exu_top.sv
// Module: execute unit top. Routes the operands to the arithmetic, shifter
// and compare units, selects the result by code class, and registers it.
// Assumes a synchronous active-low reset. The result holds while idle.
module sr_exu_top
    import sr_exu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [AMT_W-1:0]  imm_amt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    logic [AMT_W-1:0]  amt_sel;
    shift_kind_e       kind;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] shift_y;
    logic [DATA_W-1:0] cmp_y;
    logic [DATA_W-1:0] res_d;

    // Choose the amount source and the shifter variant from the code.
    always_comb begin
        amt_sel = op_is_imm(op_sel) ? imm_amt : opnd_b[AMT_W-1:0];
        unique case (op_sel)
            OP_SLL, OP_SLLI: kind = SK_SHL;
            OP_SRL, OP_SRLI: kind = SK_SHR;
            OP_SRA, OP_SRAI: kind = SK_SAR;
            OP_ROL, OP_ROLI: kind = SK_ROL;
            OP_ROR:          kind = SK_ROR;
            default:         kind = SK_SHL;
        endcase
    end

    sr_exu_arith #(.W(DATA_W)) u_arith (
        .op (op_sel),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (arith_y)
    );

    sr_exu_shift #(.W(DATA_W), .AW(AMT_W)) u_shift (
        .din  (opnd_a),
        .amt  (amt_sel),
        .kind (kind),
        .dout (shift_y)
    );

    sr_exu_cmp #(.W(DATA_W)) u_cmp (
        .op (op_sel),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (cmp_y)
    );

    // Pick the unit whose class matches the code. Unused codes give zero.
    always_comb begin
        if (op_sel <= OP_NOR) begin
            res_d = arith_y;
        end else if (op_is_shift(op_sel)) begin
            res_d = shift_y;
        end else if (op_is_cmp(op_sel)) begin
            res_d = cmp_y;
        end else begin
            res_d = '0;
        end
    end

    // Output register: load on valid, hold when idle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_d;
            end
        end
    end

    p_valid_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    p_cmp_bool_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_cmp(op_sel)) |=> (result[DATA_W-1:1] == '0));

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel > OP_CMPGEU)) |=> (result == '0));

    p_zero_amt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_shift(op_sel) && (amt_sel == '0)) |=> (result == $past(opnd_a)));

    p_rot_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_rot(op_sel)) |=> ($countones(result) == $countones($past(opnd_a))));

endmodule

// File: tb/tb_sr_exu_top.sv
// Scoreboard bench: the driver queues expected values, the monitor checks them.
module tb_sr_exu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  imm_amt = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    sr_exu_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .imm_amt   (imm_amt),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] rotl(logic [31:0] a, int n);
        return (n == 0) ? a : ((a << n) | (a >> (32 - n)));
    endfunction

    function automatic logic [31:0] rotr(logic [31:0] a, int n);
        return (n == 0) ? a : ((a >> n) | (a << (32 - n)));
    endfunction

    // Reference values written straight from the requirements.
    function automatic logic [31:0] ref_fn(int op, logic [31:0] a, logic [31:0] b, logic [4:0] imm);
        int rn = int'(b[4:0]);
        int in = int'(imm);
        case (op)
            0:  return a + b;
            1:  return a - b;
            2:  return a & b;
            3:  return a | b;
            4:  return a ^ b;
            5:  return ~(a | b);
            6:  return a << rn;
            7:  return a >> rn;
            8:  return $unsigned($signed(a) >>> rn);
            9:  return rotl(a, rn);
            10: return rotr(a, rn);
            11: return a << in;
            12: return a >> in;
            13: return $unsigned($signed(a) >>> in);
            14: return rotl(a, in);
            15: return {31'b0, a == b};
            16: return {31'b0, a != b};
            17: return {31'b0, $signed(a) < $signed(b)};
            18: return {31'b0, $signed(a) >= $signed(b)};
            19: return {31'b0, a < b};
            20: return {31'b0, a >= b};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(int op);
        if (op <= 1)  return "R1";
        if (op <= 5)  return "R2";
        if (op == 6)  return "R3 R5";
        if (op <= 8)  return "R3 R5";
        if (op <= 10) return "R3 R6";
        if (op <= 13) return "R4 R5";
        if (op == 14) return "R4 R6";
        if (op <= 16) return "R9 R10";
        if (op <= 18) return "R7 R10";
        if (op <= 20) return "R8 R10";
        return "R11";
    endfunction

    // Driver: present one operation and queue its expected result.
    task automatic drive(int op, logic [31:0] a, logic [31:0] b, logic [4:0] imm);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op[4:0];
        opnd_a   = a;
        opnd_b   = b;
        imm_amt  = imm;
        exp_q.push_back(ref_fn(op, a, b, imm));
        tag_q.push_back($sformatf("%s op=%0d a=%h b=%h imm=%0d", req_of(op), op, a, b, imm));
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: shortly after each edge, pop and compare any fresh result.
    always @(posedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), result, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [31:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                  32'h7FFF_FFFF, 32'h8000_0001, 32'hDEAD_BEEF, 32'h1234_5678};

    initial begin
        // Reset with valid high: reset must dominate (R12).
        in_valid = 1'b1;
        opnd_a   = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #2;
        check("R12 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R12 reset result", result, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Corner amounts 0, 1, 31 with upper B bits set, for every code.
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 3; k++) begin
                logic [4:0] amt = (k == 0) ? 5'd0 : (k == 1) ? 5'd1 : 5'd31;
                drive(op, 32'hB4C3_8001, {27'h5A5A5A5, amt}, amt);
                drive(op, 32'h7F00_00FE, {27'h7FFFFFF, amt}, amt);
            end
        end

        // Operand pairs across the sign boundary and equal values.
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j += 3) begin
                    drive(op, corners[i], corners[j], corners[j][4:0]);
                end
            end
        end

        // Random operands and amounts for every code.
        for (int op = 0; op < 32; op++) begin
            for (int r = 0; r < 40; r++) begin
                logic [31:0] ra = $urandom;
                logic [31:0] rb = $urandom;
                logic [4:0]  ri = 5'($urandom);
                drive(op, ra, (r % 4 == 0) ? ra : rb, ri);
            end
        end

        // Idle: result must hold the last value and out_valid must drop (R12).
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a   = 32'h0F0F_0F0F;
        op_sel   = 5'd0;
        repeat (2) @(posedge clk);
        #3;
        check("R12 idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R12 idle hold", result, ref_fn(31, 0, 0, 0));

        // A single operation after idle appears exactly one edge later (R12).
        drive(0, 32'h0000_0010, 32'h0000_0020, 5'd0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        check("R12 queue drained", exp_q.size(), 32'd0);
        check("R12 value held after single op", result, 32'h0000_0030);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule